// File: doc/BRIEF.md
# Triggered Sample Capture Engine

This block records a 16-channel probe bus into an on-chip buffer so that a host can later inspect what a circuit did around an event of interest. The probe word is taken on a user-selected transition of a sample strobe: either its rising or its falling transition. The strobe is seen as an ordinary input and edge-detected in the core clock domain. Each accepted sample is compared against a trigger pattern under a bit mask.

After the host arms it, the engine waits for the first sample that matches the trigger, or for any sample when triggering is switched off. It stores that sample at location 0 and then keeps storing every later sample until all 4096 locations are filled. It then stops and reports completion. A separate registered read port lets the host drain the buffer once capture is finished. The configuration inputs are plain levels. Arming is a single-cycle request that is honoured only when the engine is idle or finished.

Top module: `la_capture_core`

## Requirements
- R1: After reset the engine is idle, and all three status outputs (`waitTrig`, `capturing`, `done`) are low. At most one of them is ever high.
- R2: With `edgeSel` = 0, a sample is taken from `probeIn` in the clock cycle in which `sampleClk` is first seen high after being low.
- R3: With `edgeSel` = 1, a sample is taken in the clock cycle in which `sampleClk` is first seen low after being high.
- R4: A sample matches when it agrees with `trigValue` on every bit where `trigMask` is 1. Bits where `trigMask` is 0 are ignored in both the sample and `trigValue`.
- R5: While armed and waiting (`waitTrig` high), nothing is written. The first matching sample is stored at address 0, and `capturing` rises.
- R6: With `trigEnable` low, the first sample taken after arming is stored at address 0.
- R7: During capture, each further sample goes to the next address. After address 4095 is written, `done` rises, and later samples change neither the buffer nor the status.
- R8: An arm request while waiting or capturing is ignored.
- R9: An arm request while idle or done restarts the engine in the waiting state, with the next store going to address 0.
- R10: `rdData` shows the word at `rdAddr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| probeIn | input | 16 | Probe channels under observation |
| sampleClk | input | 1 | Sample strobe, edge-detected in the core clock domain |
| edgeSel | input | 1 | 0: sample on strobe rising edge, 1: on falling edge |
| trigMask | input | 16 | Trigger compare mask, 1 = bit is compared |
| trigValue | input | 16 | Trigger compare pattern |
| trigEnable | input | 1 | 1: wait for a match, 0: store from the first sample |
| arm | input | 1 | Single-cycle start request |
| rdAddr | input | 12 | Buffer read address |
| rdData | output | 16 | Buffer word, registered |
| waitTrig | output | 1 | Armed and waiting for a trigger |
| capturing | output | 1 | Storing samples |
| done | output | 1 | Buffer full, capture finished |

## Verification
The probe bus advances on every strobe transition, so words seen on rising edges differ from those seen on falling edges. A wrong edge choice therefore shows up directly in the stored data. The trigger is tried three ways. The first uses a full mask on a word that occurs only at a known rising edge, which separates exact matching from early or late firing. The second uses a partial mask whose pattern has non-zero bits outside the mask, which exposes a compare that does not ignore those bits. The third disables the trigger, which checks that storing starts immediately. Arm requests during capture, re-arming from the finished state and strobes arriving after completion check that the state sequence and the buffer contents are left alone when they should be.

// File: rtl/la_capture_pkg.sv
package la_capture_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_DONE    = 2'd3
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAddr;
    logic wrEn;
  } capCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic sampleValid;
    logic hit;
    logic lastAddr;
  } capStat_t;

endpackage

// File: rtl/la_capture_path.sv
module la_capture_path
  import la_capture_pkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int DEPTH    = 4096,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleClk,
  input  logic                edgeSel,
  input  logic [CHANNELS-1:0] probeIn,
  input  logic [CHANNELS-1:0] trigMask,
  input  logic [CHANNELS-1:0] trigValue,
  input  logic                trigEnable,
  input  capCtrl_t            ctrl,
  input  logic [AW-1:0]       rdAddr,
  output capStat_t            stat,
  output logic [CHANNELS-1:0] rdData
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic                strobePrev;
  logic                strobeHit;
  logic                sampleValid;
  logic [CHANNELS-1:0] sampleWord;
  logic [AW-1:0]       wrAddr;
  logic [CHANNELS-1:0] bufMem [DEPTH];

  // edge detect of the strobe in the core clock domain
  always_comb begin
    if (edgeSel) strobeHit = strobePrev & ~sampleClk;
    else         strobeHit = ~strobePrev & sampleClk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobePrev  <= 1'b0;
      sampleValid <= 1'b0;
      sampleWord  <= '0;
    end else begin
      strobePrev  <= sampleClk;
      sampleValid <= strobeHit;
      if (strobeHit) sampleWord <= probeIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr <= '0;
    end else if (ctrl.clrAddr) begin
      wrAddr <= '0;
    end else if (ctrl.wrEn && (wrAddr != LAST_ADDR)) begin
      wrAddr <= wrAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.wrEn) bufMem[wrAddr] <= sampleWord;
    rdData <= bufMem[rdAddr];
  end

  always_comb begin
    stat.sampleValid = sampleValid;
    stat.hit         = !trigEnable || (((sampleWord ^ trigValue) & trigMask) == '0);
    stat.lastAddr    = (wrAddr == LAST_ADDR);
  end

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_capture_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      arm,
  input  capStat_t  stat,
  output capCtrl_t  ctrl,
  output capState_t state
);

  capState_t stateNext;
  logic      armOk;

  always_comb begin
    armOk = arm && ((state == ST_IDLE) || (state == ST_DONE));
    ctrl.clrAddr = armOk;
    ctrl.wrEn = stat.sampleValid &&
                (((state == ST_ARMED) && stat.hit) || (state == ST_CAPTURE));
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_DONE: if (armOk) stateNext = ST_ARMED;
      ST_ARMED: begin
        if (ctrl.wrEn) stateNext = stat.lastAddr ? ST_DONE : ST_CAPTURE;
      end
      ST_CAPTURE: begin
        if (ctrl.wrEn && stat.lastAddr) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
  import la_capture_pkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int DEPTH    = 4096,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] probeIn,
  input  logic                sampleClk,
  input  logic                edgeSel,
  input  logic [CHANNELS-1:0] trigMask,
  input  logic [CHANNELS-1:0] trigValue,
  input  logic                trigEnable,
  input  logic                arm,
  input  logic [AW-1:0]       rdAddr,
  output logic [CHANNELS-1:0] rdData,
  output logic                waitTrig,
  output logic                capturing,
  output logic                done
);

  capCtrl_t  ctrl;
  capStat_t  stat;
  capState_t state;

  la_capture_path #(.CHANNELS(CHANNELS), .DEPTH(DEPTH)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .sampleClk  (sampleClk),
    .edgeSel    (edgeSel),
    .probeIn    (probeIn),
    .trigMask   (trigMask),
    .trigValue  (trigValue),
    .trigEnable (trigEnable),
    .ctrl       (ctrl),
    .rdAddr     (rdAddr),
    .stat       (stat),
    .rdData     (rdData)
  );

  la_capture_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .arm   (arm),
    .stat  (stat),
    .ctrl  (ctrl),
    .state (state)
  );

  assign waitTrig  = (state == ST_ARMED);
  assign capturing = (state == ST_CAPTURE);
  assign done      = (state == ST_DONE);

endmodule

// File: rtl/la_capture_checks.sv
module la_capture_checks (
  input logic clk,
  input logic rstN,
  input logic arm,
  input logic waitTrig,
  input logic capturing,
  input logic done
);

  a_r1_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({waitTrig, capturing, done}));

  a_r5_wait_exits_to_capture: assert property (@(posedge clk) disable iff (!rstN)
    waitTrig |=> (waitTrig || capturing || done));

  a_r7_capture_runs_to_done: assert property (@(posedge clk) disable iff (!rstN)
    capturing |=> (capturing || done));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !arm) |=> done);

  a_r8_arm_ignored_in_capture: assert property (@(posedge clk) disable iff (!rstN)
    (capturing && arm) |=> !waitTrig);

  a_r9_rearm_from_done: assert property (@(posedge clk) disable iff (!rstN)
    (done && arm) |=> waitTrig);

endmodule

bind la_capture_core la_capture_checks u_checks (
  .clk       (clk),
  .rstN      (rstN),
  .arm       (arm),
  .waitTrig  (waitTrig),
  .capturing (capturing),
  .done      (done)
);

// File: tb/la_capture_core_test.sv
module la_capture_core_test;

  localparam int DEPTH = 4096;
  localparam int AW    = 12;
  localparam int LIMIT = 190000;

  localparam int M_IDLE = 0, M_ARMED = 1, M_CAP = 2, M_DONE = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [15:0]   probeV = '0;
  logic          sclkV = 1'b0;
  logic          edgeSelV = 1'b0;
  logic [15:0]   maskV = '0;
  logic [15:0]   valueV = '0;
  logic          trigEnV = 1'b1;
  logic          armV = 1'b0;
  logic [AW-1:0] rdAddrV = '0;
  logic [15:0]   rdData;
  logic          waitTrig, capturing, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int idx = 0;
  bit half = 1'b0;

  // reference model state
  int          mState = M_IDLE;
  int          mAddr = 0;
  logic        mPrev = 1'b0;
  logic        mValid = 1'b0;
  logic [15:0] mSample = '0;
  logic [15:0] refMem [DEPTH];

  always #2.5 clk = ~clk;

  la_capture_core uut (
    .clk        (clk),
    .rstN       (rstN),
    .probeIn    (probeV),
    .sampleClk  (sclkV),
    .edgeSel    (edgeSelV),
    .trigMask   (maskV),
    .trigValue  (valueV),
    .trigEnable (trigEnV),
    .arm        (armV),
    .rdAddr     (rdAddrV),
    .rdData     (rdData),
    .waitTrig   (waitTrig),
    .capturing  (capturing),
    .done       (done)
  );

  function automatic logic [15:0] pat(input int n);
    logic [31:0] p;
    p = n * 32'h9E37 + 32'h1234;
    return p[15:0];
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on every rising clock
  always @(posedge clk) begin
    if (!rstN) begin
      mState = M_IDLE; mAddr = 0; mPrev = 1'b0; mValid = 1'b0; mSample = '0;
    end else begin
      bit stb, store;
      stb = edgeSelV ? (mPrev && !sclkV) : (!mPrev && sclkV);
      store = 1'b0;
      if (mValid) begin
        if (mState == M_CAP) store = 1'b1;
        if (mState == M_ARMED && (!trigEnV || ((mSample & maskV) == (valueV & maskV))))
          store = 1'b1;
      end
      if (store) begin
        refMem[mAddr] = mSample;
        if (mAddr == DEPTH - 1) mState = M_DONE;
        else begin
          mAddr++;
          mState = M_CAP;
        end
      end
      if (armV && (mState == M_IDLE || mState == M_DONE) && !store) begin
        mState = M_ARMED;
        mAddr = 0;
      end
      mValid = stb;
      if (stb) mSample = probeV;
      mPrev = sclkV;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d cycles", cycles, LIMIT);
      finishRun();
    end
  end

  // one clock: compare status against the model, then advance the probe
  task automatic tick();
    logic [2:0] expFlags;
    @(negedge clk);
    expFlags = {mState == M_ARMED, mState == M_CAP, mState == M_DONE};
    check("R5 R7 R8 R9 status", {13'd0, waitTrig, capturing, done}, {13'd0, expFlags});
    half = ~half;
    if (half) begin
      idx++;
      sclkV = idx[0];
      probeV = pat(idx);
    end
  endtask

  task automatic pulseArm();
    armV = 1'b1;
    tick();
    armV = 1'b0;
  endtask

  task automatic runToDone(input bit poke);
    int n;
    n = 0;
    while (mState != M_DONE && n < 60000) begin
      tick();
      n++;
      if (poke && n == 400) pulseArm(); // R8: arm during waiting or capture is ignored
    end
  endtask

  // R10: address presented at one negedge, data checked at the next
  task automatic readBack(input string tag);
    for (int i = 0; i <= DEPTH; i++) begin
      tick();
      if (i > 0) check(tag, rdData, refMem[i-1]);
      if (i < DEPTH) rdAddrV = AW'(i);
    end
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1: idle after reset
    check("R1 reset status", {13'd0, waitTrig, capturing, done}, 16'd0);

    // Test A: rising edge, full mask, word reached only on a rising edge (R2 R4 R5)
    edgeSelV = 1'b0; maskV = 16'hFFFF; trigEnV = 1'b1;
    t = idx + 61;
    if (t % 2 == 0) t++;
    valueV = pat(t);
    pulseArm();
    runToDone(1'b1);
    repeat (40) tick(); // R7: strobes after done store nothing
    readBack("R2 R4 R7 R10 readback");
    rdAddrV = '0;
    tick(); tick();
    check("R5 trigger word at address 0", rdData, pat(t));

    // Test B: falling edge, partial mask with don't-care value bits, re-arm from done (R3 R4 R9)
    edgeSelV = 1'b1; maskV = 16'h00F0; valueV = 16'hAB5C;
    pulseArm();
    runToDone(1'b0);
    repeat (40) tick();
    readBack("R3 R4 R9 readback");
    rdAddrV = '0;
    tick(); tick();
    check("R4 masked nibble at address 0", {12'd0, rdData[7:4]}, 16'h0005);

    // Test C: trigger disabled, stores from first sample after arming (R6)
    edgeSelV = 1'b0; trigEnV = 1'b0; maskV = 16'hFFFF; valueV = 16'h0000;
    pulseArm();
    runToDone(1'b1);
    readBack("R6 R7 readback");

    finishRun();
  end

endmodule